// File: doc/BRIEF.md
# Floating-point control/status register unit

This block holds the architectural control and status word of a single-precision floating-point unit: a three-bit dynamic rounding mode and five sticky exception flags, packed into the low eight bits of a 32-bit register whose upper bits always read as zero. The CSR execution stage reaches the word through three overlapping views. One view covers the whole register, one covers only the rounding mode and one covers only the flags. Each access returns the current contents of its view on the same cycle. When the access carries a write, the new value from a register source or from a five-bit immediate takes effect at the next clock edge. This makes every access an atomic swap.

In the same cycle, the block resolves the rounding field of an issuing arithmetic instruction against the dynamic mode. It flags an illegal instruction when dynamic rounding is selected while the stored mode is a reserved code. It also ORs in the exception flags reported by the arithmetic units. Those flags stay set until software overwrites them, and a software write that meets a flag report in the same cycle keeps both.

Top module: `fpcsr_unit`

## Requirements
- R1: With view code 0 (whole register), `acc_rdata` equals `{24'b0, frm, fflags}`: rounding mode in bits 7:5, flags in bits 4:0 (invalid 4, divide-by-zero 3, overflow 2, underflow 1, inexact 0), all higher bits zero.
- R2: A whole-register write (view 0, `acc_write`=1) returns the old value on `acc_rdata` in that cycle. After the next rising clock edge, `frm` equals source bits 7:5 and `fflags` equals source bits 4:0.
- R3: With view code 1 (rounding mode), `acc_rdata` equals `frm` in bits 2:0 with every other bit zero. A write stores source bits 2:0 into `frm` and leaves the stored flags as they were.
- R4: With view code 2 (flags), `acc_rdata` equals `fflags` in bits 4:0 with every other bit zero. A write stores source bits 4:0 into `fflags` and leaves `frm` as it was.
- R5: When `acc_use_imm`=1, the write value is `acc_imm` zero-extended in place of `acc_src`, for every view.
- R6: An access with `acc_write`=0 changes no state. View code 3 reads as zero and never changes state.
- R7: `eff_rm` equals `instr_rm`, except when `instr_rm` is 111, in which case it equals the stored `frm` (000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero).
- R8: `illegal_rm` is 1 exactly when `op_valid`=1, `instr_rm`=111 and the stored `frm` is 101, 110 or 111.
- R9: When `flag_valid`=1, each set bit of `flag_in` is ORed into `fflags` at the next edge. Without a flag write, no stored flag ever clears.
- R10: When a flag-covering write and a flag report occur in the same cycle, the stored flags become the written flags ORed with `flag_in`.
- R11: After reset, `frm` and `fflags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Software access this cycle |
| acc_view | input | 2 | 0 whole, 1 rounding mode, 2 flags, 3 none |
| acc_write | input | 1 | Access is a swap (writes new value) |
| acc_use_imm | input | 1 | Take write value from immediate |
| acc_src | input | 8 | Low bits of the source register |
| acc_imm | input | 5 | Immediate operand |
| acc_rdata | output | 32 | Old contents of the selected view |
| op_valid | input | 1 | Arithmetic instruction issuing |
| instr_rm | input | 3 | Instruction rounding field |
| eff_rm | output | 3 | Resolved rounding mode |
| illegal_rm | output | 1 | Dynamic rounding with reserved stored mode |
| flag_valid | input | 1 | Arithmetic unit reports flags |
| flag_in | input | 5 | Reported exception flags |
| frm | output | 3 | Stored rounding mode |
| fflags | output | 5 | Stored sticky flags |

## Verification
The hardest situations to reach are the coincidences. One is a flag-covering software write that lands in the same cycle as a hardware flag report. The other is a dynamic-rounding instruction that issues while the stored mode holds a reserved code, which needs a prior write of such a code. Directed steps create both on purpose. A long random phase then mixes them freely: writes of random source values leave the mode reserved three times in eight, and flag reports arrive independently of accesses.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int RM_W    = 3;
    localparam int FLAG_W  = 5;
    localparam int FIELD_W = RM_W + FLAG_W;
    localparam int IMM_W   = 5;

    typedef enum logic [1:0] {
        VIEW_ALL   = 2'd0,
        VIEW_RM    = 2'd1,
        VIEW_FLAGS = 2'd2,
        VIEW_NONE  = 2'd3
    } view_e;

    typedef struct packed {
        logic [RM_W-1:0]   rm;
        logic [FLAG_W-1:0] flags;
    } csr_state_t;

    localparam logic [RM_W-1:0] RM_DYNAMIC   = 3'b111;
    localparam logic [RM_W-1:0] RM_LAST_LEGAL = 3'b100;
endpackage

// File: rtl/fpcsr_view_read.sv
module fpcsr_view_read
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_state_t      st,
    input  view_e           view,
    output logic [XLEN-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (view)
            VIEW_ALL:   rdata[FIELD_W-1:0] = st;
            VIEW_RM:    rdata[RM_W-1:0]    = st.rm;
            VIEW_FLAGS: rdata[FLAG_W-1:0]  = st.flags;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/fpcsr_view_write.sv
module fpcsr_view_write
    import fpcsr_pkg::*;
(
    input  csr_state_t         st,
    input  logic               wr_en,
    input  view_e              view,
    input  logic [FIELD_W-1:0] wval,
    input  logic               acc_en,
    input  logic [FLAG_W-1:0]  acc_flags,
    output csr_state_t         st_next
);
    csr_state_t        merged;
    logic [FLAG_W-1:0] flags_acc;

    always_comb begin
        merged = st;
        if (wr_en) begin
            case (view)
                VIEW_ALL:   merged       = csr_state_t'(wval);
                VIEW_RM:    merged.rm    = wval[RM_W-1:0];
                VIEW_FLAGS: merged.flags = wval[FLAG_W-1:0];
                default:    merged       = st;
            endcase
        end
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_sticky
        assign flags_acc[i] = merged.flags[i] | (acc_en & acc_flags[i]);
    end

    assign st_next = '{rm: merged.rm, flags: flags_acc};
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
    import fpcsr_pkg::*;
(
    input  logic            op_valid,
    input  logic [RM_W-1:0] instr_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            illegal
);
    logic dyn_sel;

    always_comb begin
        dyn_sel = (instr_rm == RM_DYNAMIC);
        eff_rm  = dyn_sel ? dyn_rm : instr_rm;
        illegal = op_valid & dyn_sel & (dyn_rm > RM_LAST_LEGAL);
    end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [1:0]         acc_view,
    input  logic               acc_write,
    input  logic               acc_use_imm,
    input  logic [FIELD_W-1:0] acc_src,
    input  logic [IMM_W-1:0]   acc_imm,
    output logic [XLEN-1:0]    acc_rdata,
    input  logic               op_valid,
    input  logic [RM_W-1:0]    instr_rm,
    output logic [RM_W-1:0]    eff_rm,
    output logic               illegal_rm,
    input  logic               flag_valid,
    input  logic [FLAG_W-1:0]  flag_in,
    output logic [RM_W-1:0]    frm,
    output logic [FLAG_W-1:0]  fflags
);
    csr_state_t         state_d, state_q, state_nx;
    logic [FIELD_W-1:0] wval;
    logic               wr_en;
    view_e              view;
    view_e              rd_view;

    always_comb begin
        view    = view_e'(acc_view);
        rd_view = acc_valid ? view : VIEW_NONE;
        wr_en   = acc_valid & acc_write;
        wval    = acc_use_imm ? {{(FIELD_W-IMM_W){1'b0}}, acc_imm} : acc_src;
        state_d = state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    fpcsr_view_write u_write (
        .st        (state_q),
        .wr_en     (wr_en),
        .view      (view),
        .wval      (wval),
        .acc_en    (flag_valid),
        .acc_flags (flag_in),
        .st_next   (state_nx)
    );

    fpcsr_view_read #(.XLEN(XLEN)) u_read (
        .st    (state_q),
        .view  (rd_view),
        .rdata (acc_rdata)
    );

    fpcsr_rm_resolve u_rm (
        .op_valid (op_valid),
        .instr_rm (instr_rm),
        .dyn_rm   (state_q.rm),
        .eff_rm   (eff_rm),
        .illegal  (illegal_rm)
    );

    assign frm    = state_q.rm;
    assign fflags = state_q.flags;
endmodule

// File: rtl/fpcsr_unit_chk.sv
module fpcsr_unit_chk
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_view,
    input logic              acc_write,
    input logic [XLEN-1:0]   acc_rdata,
    input logic              op_valid,
    input logic [RM_W-1:0]   instr_rm,
    input logic [RM_W-1:0]   eff_rm,
    input logic              illegal_rm,
    input logic              flag_valid,
    input logic [FLAG_W-1:0] flag_in,
    input logic [RM_W-1:0]   frm,
    input logic [FLAG_W-1:0] fflags
);
    logic wr_flags, wr_mode;
    assign wr_flags = acc_valid && acc_write && (acc_view == 2'd0 || acc_view == 2'd2);
    assign wr_mode  = acc_valid && acc_write && (acc_view == 2'd0 || acc_view == 2'd1);

    // R1
    whole_view_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_view == 2'd0) |->
        (acc_rdata[XLEN-1:FIELD_W] == '0 && acc_rdata[FIELD_W-1:0] == {frm, fflags}));

    // R3
    mode_view_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_view == 2'd1) |-> (acc_rdata == XLEN'(frm)));

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flags |=> ((fflags & $past(fflags)) == $past(fflags)));

    // R9
    flags_accrue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |=> ((fflags & $past(flag_in)) == $past(flag_in)));

    // R4
    mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(frm));

    // R7
    static_rm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_rm != 3'b111) |-> (eff_rm == instr_rm));

    // R8
    illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_rm |-> (op_valid && instr_rm == 3'b111 && frm > 3'b100));
endmodule

bind fpcsr_unit fpcsr_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/fpcsr_unit_tb.sv
module fpcsr_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_write = 0, acc_use_imm = 0;
    logic [1:0]  acc_view = 0;
    logic [7:0]  acc_src = 0;
    logic [4:0]  acc_imm = 0;
    logic [31:0] acc_rdata;
    logic        op_valid = 0;
    logic [2:0]  instr_rm = 0;
    logic [2:0]  eff_rm;
    logic        illegal_rm;
    logic        flag_valid = 0;
    logic [4:0]  flag_in = 0;
    logic [2:0]  frm;
    logic [4:0]  fflags;

    int errors = 0;
    int checks = 0;
    logic [2:0] m_rm = 0;
    logic [4:0] m_fl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcsr_unit u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        if (!acc_valid) return 32'h0;
        case (acc_view)
            2'd0: return {24'h0, m_rm, m_fl};
            2'd1: return {29'h0, m_rm};
            2'd2: return {27'h0, m_fl};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag();
        case (acc_view)
            2'd0: return "R1";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(input bit av, input logic [1:0] vw, input bit wr, input bit ui,
                         input logic [7:0] src, input logic [4:0] imm,
                         input bit ov, input logic [2:0] rm, input bit fv, input logic [4:0] fin);
        acc_valid = av; acc_view = vw; acc_write = wr; acc_use_imm = ui;
        acc_src = src; acc_imm = imm; op_valid = ov; instr_rm = rm;
        flag_valid = fv; flag_in = fin;
    endtask

    // Checks combinational outputs, clocks once, updates model, checks state.
    task automatic step();
        logic [7:0] w;
        logic [2:0] e_rm;
        bit wr;
        string st_tag;
        #1;
        chk(acc_rdata == exp_rdata(), rd_tag(), acc_rdata, exp_rdata());
        e_rm = (instr_rm == 3'b111) ? m_rm : instr_rm;
        chk(eff_rm == e_rm, "R7", {29'h0, eff_rm}, {29'h0, e_rm});
        chk(illegal_rm == (op_valid && instr_rm == 3'b111 && m_rm > 3'd4), "R8",
            {31'h0, illegal_rm}, {31'h0, op_valid && instr_rm == 3'b111 && m_rm > 3'd4});
        w  = acc_use_imm ? {3'b000, acc_imm} : acc_src;
        wr = acc_valid && acc_write && acc_view != 2'd3;
        if (wr && flag_valid && acc_view != 2'd1) st_tag = "R10";
        else if (wr && acc_use_imm) st_tag = "R5";
        else if (wr) st_tag = (acc_view == 2'd0) ? "R2" : (acc_view == 2'd1) ? "R3" : "R4";
        else st_tag = flag_valid ? "R9" : "R6";
        @(posedge clk);
        if (wr) begin
            case (acc_view)
                2'd0: begin m_rm = w[7:5]; m_fl = w[4:0]; end
                2'd1: m_rm = w[2:0];
                default: m_fl = w[4:0];
            endcase
        end
        if (flag_valid) m_fl = m_fl | flag_in;
        @(negedge clk);
        chk({frm, fflags} == {m_rm, m_fl}, st_tag, {24'h0, frm, fflags}, {24'h0, m_rm, m_fl});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({frm, fflags} == 8'h0, "R11", {24'h0, frm, fflags}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({frm, fflags} == 8'h0, "R11", {24'h0, frm, fflags}, 32'h0);

        // R2: whole swap, then R1 read
        drive(1, 2'd0, 1, 0, 8'hE5, 0, 0, 0, 0, 0); step();
        drive(1, 2'd0, 0, 0, 8'h00, 0, 0, 0, 0, 0); step();
        // R8: dynamic with reserved 111; R7: static passes
        drive(0, 0, 0, 0, 0, 0, 1, 3'b111, 0, 0); step();
        drive(0, 0, 0, 0, 0, 0, 1, 3'b011, 0, 0); step();
        // R3 + R5: mode swap from immediate 11010 -> 010
        drive(1, 2'd1, 1, 1, 8'hFF, 5'b11010, 0, 0, 0, 0); step();
        // R10: flag swap to 0 with same-cycle report
        drive(1, 2'd2, 1, 0, 8'h00, 0, 0, 0, 1, 5'b00010); step();
        // R9: accrue, then hold
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b10000); step();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); step();
        // R6: read-only and view 3 write have no effect
        drive(1, 2'd2, 0, 0, 8'hFF, 0, 0, 0, 0, 0); step();
        drive(1, 2'd3, 1, 0, 8'hFF, 5'h1F, 0, 0, 0, 0); step();
        // R8: mode 101 illegal, 100 legal
        drive(1, 2'd1, 1, 0, 8'h05, 0, 0, 0, 0, 0); step();
        drive(0, 0, 0, 0, 0, 0, 1, 3'b111, 0, 0); step();
        drive(1, 2'd1, 1, 1, 0, 5'b00100, 1, 3'b111, 0, 0); step();
        drive(0, 0, 0, 0, 0, 0, 1, 3'b111, 0, 0); step();
        // R4: flag swap from immediate keeps mode
        drive(1, 2'd2, 1, 1, 0, 5'b01001, 0, 0, 0, 0); step();

        for (int i = 0; i < 3000; i++) begin
            drive($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
                  $urandom_range(0, 3) == 0, 8'($urandom), 5'($urandom),
                  $urandom_range(0, 1) == 1, 3'($urandom), $urandom_range(0, 9) < 3,
                  ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'(1 << $urandom_range(0, 4)));
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule